// File: doc/BRIEF.md
# Self-Masking Dual-Half Lookup Table

This is a configurable lookup-table cell that holds one 5-input truth table of 32 entries. It keeps an identical copy of that table in each of two storage halves. For a given input code, each half is read at the same entry. A carry-style majority stage merges the two half outputs. The third input of that stage is the carry-select line. With the select low the stage acts as an AND of the halves, so a stray 0→1 flip in one copy cannot reach the output. With the select high it acts as an OR, and a stray 1→0 flip is masked in the same way. The select should be driven low when the table holds mostly zeros and high when it holds mostly ones.

The table and a small recovery control field arrive over a serial configuration port, most significant bit first. Both halves take the new content together, and only when the last bit of the word arrives. The stored table may have been built with its entries inverted wherever a chosen input line is 1, or wherever it is 0. An optional recovery stage then XORs or XNORs the merged value with that input line to give back the true function. A fault port flips any single stored bit in either half, so that masking can be exercised. The output is registered.

Top module: `dual_half_lut`

## Requirements
- R1: After reset both halves hold all zeros, recovery is disabled, and `data_o` is 0.
- R2: A configuration word is 37 bits, shifted in MSB first, one bit per cycle while `cfg_valid_i` is high. Word bit 36 is the recovery enable, bit 35 is the polarity, bits 34:32 are the input index and bits 31:0 are the table. Both halves and the recovery fields change only in the cycle that takes the 37th bit. Until then the old content stays in use.
- R3: Table entry k is the function value for input code k on `func_i`. `data_o` shows the result for the inputs sampled at the previous rising clock edge.
- R4: The merged value is cin·a + cin·b + a·b, where a and b are the two half outputs. With `cin_i`=0 this gives a AND b, and with `cin_i`=1 it gives a OR b.
- R5: With `cin_i`=0, a single 0→1 flip of any entry in either half leaves `data_o` equal to the true table for every input code.
- R6: With `cin_i`=1, a single 1→0 flip of any entry in either half leaves `data_o` equal to the true table for every input code.
- R7: A cycle with `fault_en_i` high inverts exactly one stored bit: the entry at `fault_addr_i` in half `fault_half_i` (0 or 1). The flip persists until the next configuration load. A flip of the type the current select does not mask shows up at the output.
- R8: With recovery disabled, `data_o` is the merged value unchanged.
- R9: With recovery enabled, polarity 0 gives the merged value XOR `func_i[idx]`, and polarity 1 gives the merged value XNOR `func_i[idx]`.
- R10: A recovery index of 5, 6 or 7 selects a constant 0 in place of an input line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Serial configuration bit strobe |
| cfg_bit_i | input | 1 | Serial configuration data, MSB first |
| fault_en_i | input | 1 | Flip one stored bit this cycle |
| fault_half_i | input | 1 | Half selected for the flip |
| fault_addr_i | input | 5 | Entry selected for the flip |
| func_i | input | 5 | Function input code |
| cin_i | input | 1 | Carry select: 0 AND masking, 1 OR masking |
| data_o | output | 1 | Registered function output |

## Verification
The bench builds the cell with its default parameters: 5 function inputs, which gives 32 entries, and a 3-bit recovery index. At that size every entry of both halves can have a fault injected, and every input code can be swept after each flip. This makes the masking claims exhaustive for single flips under both select values. The 3-bit index also reaches the three codes beyond the real input lines, so the constant-zero recovery case is covered. A partial 36-bit load exercises the rule that new content is held back until the final bit.

// File: rtl/dhl_pkg.sv
package dhl_pkg;
  localparam int unsigned REC_IDX_W = 3;
  localparam int unsigned REC_W     = REC_IDX_W + 2;

  typedef struct packed {
    logic                 en;
    logic                 pol;
    logic [REC_IDX_W-1:0] idx;
  } rec_cfg_t;
endpackage

// File: rtl/dhl_cfg_shift.sv
module dhl_cfg_shift #(
  parameter int unsigned CFG_W = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             bit_i,
  output logic             commit_o,
  output logic [CFG_W-1:0] word_o
);
  localparam int unsigned CW = $clog2(CFG_W + 1);

  logic [CFG_W-2:0] sr_q;
  logic [CW-1:0]    cnt_q;

  assign commit_o = valid_i && (cnt_q == CW'(CFG_W - 1));
  assign word_o   = {sr_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (valid_i) begin
      sr_q  <= word_o[CFG_W-2:0];
      cnt_q <= commit_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(CFG_W));
endmodule

// File: rtl/dhl_half_table.sv
module dhl_half_table #(
  parameter int unsigned AW = 5,
  localparam int unsigned ENTRIES = 1 << AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [ENTRIES-1:0] load_i,
  input  logic               flip_i,
  input  logic [AW-1:0]      flip_addr_i,
  input  logic [AW-1:0]      addr_i,
  output logic               bit_o
);
  logic [ENTRIES-1:0] mem_q;

  assign bit_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mem_q <= '0;
    else if (commit_i) mem_q <= load_i;
    else if (flip_i)   mem_q[flip_addr_i] <= ~mem_q[flip_addr_i];
  end

  // R2
  load_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> mem_q == $past(load_i));
  // R7
  single_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_i && !commit_i) |=> $countones(mem_q ^ $past(mem_q)) == 1);
endmodule

// File: rtl/dhl_mask_combine.sv
module dhl_mask_combine
  import dhl_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          o5_i,
  input  logic          o6_i,
  input  logic          cin_i,
  input  rec_cfg_t      rec_i,
  input  logic [AW-1:0] func_i,
  output logic          maj_o,
  output logic          y_o
);
  localparam int unsigned PADW = 1 << REC_IDX_W;

  logic [PADW-1:0] pad;
  logic            sel_in;

  // carry-style majority: select input picks AND (0) or OR (1)
  assign maj_o = (cin_i & o5_i) | (cin_i & o6_i) | (o5_i & o6_i);

  generate
    if (PADW > AW) begin : g_pad
      assign pad = {{(PADW - AW){1'b0}}, func_i};
    end else begin : g_nopad
      assign pad = func_i[PADW-1:0];
    end
  endgenerate

  assign sel_in = pad[rec_i.idx];
  assign y_o    = rec_i.en ? (maj_o ^ sel_in ^ rec_i.pol) : maj_o;
endmodule

// File: rtl/dual_half_lut.sv
module dual_half_lut
  import dhl_pkg::*;
#(
  parameter int unsigned AW = 5,
  localparam int unsigned ENTRIES = 1 << AW,
  localparam int unsigned CFG_W   = ENTRIES + REC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_valid_i,
  input  logic          cfg_bit_i,
  input  logic          fault_en_i,
  input  logic          fault_half_i,
  input  logic [AW-1:0] fault_addr_i,
  input  logic [AW-1:0] func_i,
  input  logic          cin_i,
  output logic          data_o
);
  logic             commit;
  logic [CFG_W-1:0] word;
  logic [1:0]       half_bit;
  rec_cfg_t         rec_q;
  logic             maj, y;

  dhl_cfg_shift #(.CFG_W(CFG_W)) u_shift (
    .clk_i, .rst_ni, .valid_i(cfg_valid_i), .bit_i(cfg_bit_i),
    .commit_o(commit), .word_o(word)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    dhl_half_table #(.AW(AW)) u_tbl (
      .clk_i, .rst_ni,
      .commit_i   (commit),
      .load_i     (word[ENTRIES-1:0]),
      .flip_i     (fault_en_i && (fault_half_i == 1'(g))),
      .flip_addr_i(fault_addr_i),
      .addr_i     (func_i),
      .bit_o      (half_bit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rec_q <= '0;
    else if (commit) rec_q <= rec_cfg_t'(word[CFG_W-1 -: REC_W]);
  end

  dhl_mask_combine #(.AW(AW)) u_comb (
    .o5_i(half_bit[0]), .o6_i(half_bit[1]), .cin_i, .rec_i(rec_q),
    .func_i, .maj_o(maj), .y_o(y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= 1'b0;
    else         data_o <= y;
  end

  // R4
  and_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_q.en && !cin_i) |=> data_o == $past(half_bit[0] && half_bit[1]));
  // R4
  or_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_q.en && cin_i) |=> data_o == $past(half_bit[0] || half_bit[1]));
  // R8
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_q.en |=> data_o == $past(maj));
  // R9
  xor_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_q.en && !rec_q.pol && rec_q.idx == '0) |=> data_o == ($past(maj) ^ $past(func_i[0])));
  // R10
  zero_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_q.en && rec_q.idx >= REC_IDX_W'(AW)) |=> data_o == ($past(maj) ^ $past(rec_q.pol)));
endmodule

// File: tb/dual_half_lut_bench.sv
module dual_half_lut_bench;
  localparam int AW = 5;
  localparam int EN = 1 << AW;
  localparam int CW = EN + 5;

  logic clk = 0, rst_ni = 0;
  logic cfg_valid = 0, cfg_bit = 0, fault_en = 0, fault_half = 0, cin = 0;
  logic [AW-1:0] fault_addr = '0, func = '0;
  logic data_o;

  dual_half_lut #(.AW(AW)) u_dual_half_lut (
    .clk_i(clk), .rst_ni, .cfg_valid_i(cfg_valid), .cfg_bit_i(cfg_bit),
    .fault_en_i(fault_en), .fault_half_i(fault_half), .fault_addr_i(fault_addr),
    .func_i(func), .cin_i(cin), .data_o
  );

  always #10 clk = ~clk;

  int vectors = 0, misses = 0;
  logic [EN-1:0] tbl = '0, fa = '0, fb = '0;
  bit m_en = 0, m_pol = 0;
  int m_idx = 0;
  bit    exp_q[$];
  string tag_q[$];

  function automatic bit model(int code, bit c);
    bit a, b, r, x;
    a = tbl[code] ^ fa[code];
    b = tbl[code] ^ fb[code];
    r = c ? (a | b) : (a & b);
    x = (m_idx < AW) ? code[m_idx] : 1'b0;
    if (m_en) r = r ^ x ^ m_pol;
    return r;
  endfunction

  task automatic apply(int code, bit c, string tag);
    @(negedge clk);
    func = AW'(code); cin = c;
    @(posedge clk); #1;
    exp_q.push_back(model(code, c));
    tag_q.push_back(tag);
  endtask

  task automatic sweep(bit c, string tag);
    for (int k = 0; k < EN; k++) apply(k, c, tag);
  endtask

  task automatic send_bits(logic [CW-1:0] w, int hi, int lo);
    for (int i = hi; i >= lo; i--) begin
      @(negedge clk); cfg_valid = 1; cfg_bit = w[i];
    end
    @(negedge clk); cfg_valid = 0;
  endtask

  task automatic load(logic [EN-1:0] t, bit en, bit pol, int idx);
    send_bits({en, pol, 3'(idx), t}, CW - 1, 0);
    tbl = t; fa = '0; fb = '0; m_en = en; m_pol = pol; m_idx = idx;
  endtask

  task automatic flip(bit h, int a);
    @(negedge clk); fault_en = 1; fault_half = h; fault_addr = AW'(a);
    @(negedge clk); fault_en = 0;
    if (h) fb[a] = ~fb[a]; else fa[a] = ~fa[a];
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      vectors++;
      if (data_o !== e) begin
        misses++;
        $display("FAIL %s: data_o=%b expected %b", t, data_o, e);
      end
    end
  end

  initial begin
    #3000000;
    misses++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [EN-1:0] t1, t2;
    t1 = 32'h0810_2443;
    t2 = 32'hF7EF_DBBC;
    repeat (3) @(negedge clk);
    vectors++;
    if (data_o !== 1'b0) begin
      misses++; $display("FAIL R1: data_o=%b expected 0", data_o);
    end
    rst_ni = 1;
    apply(7, 0, "R1"); apply(31, 1, "R1");

    // R2: 36 of 37 bits leave old (zero) table in force
    send_bits({1'b0, 1'b0, 3'd0, t1}, CW - 1, 1);
    sweep(1, "R2");
    send_bits({1'b0, 1'b0, 3'd0, t1}, 0, 0);
    tbl = t1;
    sweep(0, "R3"); sweep(1, "R3");

    // R5: every 0->1 flip masked with AND
    for (int h = 0; h < 2; h++)
      for (int a = 0; a < EN; a++)
        if (!t1[a]) begin
          flip(h[0], a); sweep(0, "R5"); flip(h[0], a);
        end

    // R7 / R4: unmasked-type flips show through
    flip(1, 0);  apply(0, 1, "R7"); apply(0, 0, "R4");
    flip(1, 0);
    flip(0, 1);  apply(1, 0, "R7"); apply(1, 1, "R4");
    flip(0, 1);

    // R6: every 1->0 flip masked with OR
    load(t2, 0, 0, 0);
    sweep(1, "R8");
    for (int h = 0; h < 2; h++)
      for (int a = 0; a < EN; a++)
        if (t2[a]) begin
          flip(h[0], a); sweep(1, "R6"); flip(h[0], a);
        end

    // R9 recovery: XOR and XNOR
    load(t1, 1, 0, 2); sweep(0, "R9");
    load(t2, 1, 1, 4); sweep(1, "R9");
    load(t1, 1, 0, 0); sweep(0, "R9");
    // R10 out-of-range index
    load(t1, 1, 0, 6); sweep(0, "R10");
    load(t2, 1, 1, 7); sweep(1, "R10");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule